// File: doc/BRIEF.md
# Keyboard Controller Command Decoder

This block is the host-facing register front end of a PC-style keyboard and auxiliary-port controller. The host sees a byte-wide bus with two addresses. The command port (address 1) takes command bytes, and reading it returns the status byte. The data port (address 0) takes data bytes. The block keeps the mode byte, the status flags and the output-port byte. It decodes each command byte and carries out the command.

Commands that need an operand are done in two phases. The command byte only latches a pending write command, and the next data-port write supplies the operand. The block drives the A20 gate, and it issues a one-cycle system-reset request. Controller response bytes go into a one-byte mailbox. An output-buffer arbiter drains that mailbox through a valid/ready handshake.

Back-pressure rules for the mailbox:
- `rsp_valid`, `rsp_data` and `rsp_aux` stay stable while `rsp_ready` is low.
- A byte leaves the mailbox on a cycle where both `rsp_valid` and `rsp_ready` are high.
- A new response replaces a byte that has not been taken yet.

The arbiter feeds its buffer-full flags back in, and these appear in the status byte. Bytes for the keyboard and the mouse leave as one-cycle strobes. They have no back-pressure.

Top module: `kbc_cmd_decoder`

## Requirements
- R1: Command 0x20 posts the mode byte. Command 0xC0 posts 0x80. Command 0xD0 posts the output-port byte, with bit 4 replaced by `obf_in` and bit 5 replaced by `obf_aux_in`. All of these post with `rsp_aux`=0.
- R2: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 change nothing except the pending write command. The next data-port write is taken as their operand, and the pending command is then cleared. 0x60 loads the mode byte from the operand.
- R3: Command 0xAA sets status bit 2 and posts 0x55. Commands 0xA9 and 0xAB each post 0x00.
- R4: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4.
- R5: For a command byte whose upper nibble is 0xF, `sys_reset_req` pulses for exactly one cycle when bit 0 is 0. When bit 0 is 1 the command does nothing. Neither case posts a byte or flags an error.
- R6: Command 0xDF sets output-port bit 1 and raises `a20_out`. Command 0xDD clears output-port bit 1 and lowers `a20_out`.
- R7: The 0xD1 operand replaces the output-port byte. `a20_out` follows operand bit 1, and `sys_reset_req` pulses when operand bit 0 is 0.
- R8: A data-port write with no pending command raises `kbd_tx_valid` for one cycle, carrying the byte, and clears mode bit 4. The 0xD4 operand raises `aux_tx_valid` for one cycle and clears mode bit 5.
- R9: After reset, mode is 0x03, the output port is 0xCF (so `a20_out`=1), and status is 0x18. The status byte is laid out as follows:
  - bit 0 is `obf_in`
  - bit 2 is the self-test flag
  - bit 3 is 1 after a command-port write and 0 after a data-port write
  - bit 4 is always 1
  - bit 5 is `obf_aux_in`
  - all other bits are 0
- R10: A command byte outside the known set raises `cmd_err` for one cycle. It changes no mode, output-port, status, pending-command or mailbox state.
- R11: The 0xD2 operand is posted with `rsp_aux`=0 and the 0xD3 operand with `rsp_aux`=1. A posted byte is held until it is taken, and a newer post replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one byte per cycle |
| bus_addr | input | 1 | 1 = command port, 0 = data port |
| bus_wdata | input | 8 | Host write byte |
| status_o | output | 8 | Status byte, returned on command-port reads |
| obf_in | input | 1 | Arbiter output buffer full |
| obf_aux_in | input | 1 | Buffered byte came from the auxiliary channel |
| rsp_valid | output | 1 | Mailbox holds a response byte |
| rsp_data | output | 8 | Response byte |
| rsp_aux | output | 1 | Response is tagged as auxiliary |
| rsp_ready | input | 1 | Arbiter takes the response |
| kbd_tx_valid | output | 1 | One-cycle strobe: byte for the keyboard |
| aux_tx_valid | output | 1 | One-cycle strobe: byte for the mouse |
| tx_data | output | 8 | Byte for the keyboard or the mouse |
| mode_o | output | 8 | Current mode byte |
| a20_out | output | 1 | A20 gate |
| sys_reset_req | output | 1 | One-cycle system-reset request |
| cmd_err | output | 1 | One-cycle strobe for an unknown command |

## Verification
Every effect of a write is registered at the clock edge that samples the write. This covers the mailbox contents, the mode and output-port bytes, `a20_out`, the status flags, the device strobes, `sys_reset_req` and `cmd_err`, which are all valid one cycle after the write. `status_o` also follows `obf_in` and `obf_aux_in` combinationally. The bench drives each write for one cycle and samples at the falling edge right after the capturing edge. That is the only cycle in which a pulse is high, and the bench checks that pulses are low again one cycle later. The bench sweeps all sixteen 0xF_ codes and every unknown command byte.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t C_RD_MODE   = 8'h20;
  localparam byte_t C_WR_MODE   = 8'h60;
  localparam byte_t C_AUX_OFF   = 8'hA7;
  localparam byte_t C_AUX_ON    = 8'hA8;
  localparam byte_t C_AUX_TEST  = 8'hA9;
  localparam byte_t C_SELF_TEST = 8'hAA;
  localparam byte_t C_KBD_TEST  = 8'hAB;
  localparam byte_t C_KBD_OFF   = 8'hAD;
  localparam byte_t C_KBD_ON    = 8'hAE;
  localparam byte_t C_RD_INPORT = 8'hC0;
  localparam byte_t C_RD_OUTP   = 8'hD0;
  localparam byte_t C_WR_OUTP   = 8'hD1;
  localparam byte_t C_WR_KBUF   = 8'hD2;
  localparam byte_t C_WR_ABUF   = 8'hD3;
  localparam byte_t C_WR_AUXDEV = 8'hD4;
  localparam byte_t C_A20_OFF   = 8'hDD;
  localparam byte_t C_A20_ON    = 8'hDF;

  localparam int unsigned MB_KBD_DIS = 4;
  localparam int unsigned MB_AUX_DIS = 5;
  localparam int unsigned OP_A20_BIT = 1;

  typedef enum logic [3:0] {
    OP_POST_MODE, OP_POST_INPORT, OP_POST_OUTP, OP_POST_ZERO, OP_SELFTEST,
    OP_LATCH, OP_SET_AUXDIS, OP_CLR_AUXDIS, OP_SET_KBDDIS, OP_CLR_KBDDIS,
    OP_A20_UP, OP_A20_DOWN, OP_RESET, OP_NOP, OP_BAD
  } op_e;

  typedef struct packed {
    logic  mode_we;
    byte_t mode_d;
    logic  outp_we;
    byte_t outp_d;
    logic  selftest_set;
    logic  cmdflag_we;
    logic  cmdflag_d;
    logic  wcmd_we;
    byte_t wcmd_d;
  } reg_upd_t;
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  byte_t cmd,
  output op_e   op
);
  always_comb begin
    if (cmd[7:4] == 4'hF) begin
      op = cmd[0] ? OP_NOP : OP_RESET;
    end else begin
      case (cmd)
        C_RD_MODE:   op = OP_POST_MODE;
        C_RD_INPORT: op = OP_POST_INPORT;
        C_RD_OUTP:   op = OP_POST_OUTP;
        C_AUX_TEST,
        C_KBD_TEST:  op = OP_POST_ZERO;
        C_SELF_TEST: op = OP_SELFTEST;
        C_WR_MODE, C_WR_OUTP, C_WR_KBUF,
        C_WR_ABUF, C_WR_AUXDEV: op = OP_LATCH;
        C_AUX_OFF:   op = OP_SET_AUXDIS;
        C_AUX_ON:    op = OP_CLR_AUXDIS;
        C_KBD_OFF:   op = OP_SET_KBDDIS;
        C_KBD_ON:    op = OP_CLR_KBDDIS;
        C_A20_ON:    op = OP_A20_UP;
        C_A20_OFF:   op = OP_A20_DOWN;
        default:     op = OP_BAD;
      endcase
    end
  end
endmodule

// File: rtl/kbc_ctrl_regs.sv
module kbc_ctrl_regs
  import kbc_pkg::*;
#(
  parameter byte_t MODE_RST = 8'h03,
  parameter byte_t OUTP_RST = 8'hCF
) (
  input  logic     clk,
  input  logic     rst_n,
  input  reg_upd_t upd,
  output byte_t    mode_q,
  output byte_t    outp_q,
  output logic     selftest_q,
  output logic     cmdflag_q,
  output byte_t    wcmd_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_RST;
      outp_q     <= OUTP_RST;
      selftest_q <= 1'b0;
      cmdflag_q  <= 1'b1;
      wcmd_q     <= '0;
    end else begin
      if (upd.mode_we)      mode_q     <= upd.mode_d;
      if (upd.outp_we)      outp_q     <= upd.outp_d;
      if (upd.selftest_set) selftest_q <= 1'b1;
      if (upd.cmdflag_we)   cmdflag_q  <= upd.cmdflag_d;
      if (upd.wcmd_we)      wcmd_q     <= upd.wcmd_d;
    end
  end
endmodule

// File: rtl/kbc_rsp_mailbox.sv
module kbc_rsp_mailbox #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post,
  input  logic [DATA_W-1:0] post_data,
  input  logic              post_aux,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_aux,
  input  logic              rsp_ready
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_aux   <= 1'b0;
    end else if (post) begin
      rsp_valid <= 1'b1;
      rsp_data  <= post_data;
      rsp_aux   <= post_aux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/kbc_cmd_decoder.sv
module kbc_cmd_decoder
  import kbc_pkg::*;
#(
  parameter byte_t MODE_RST    = 8'h03,
  parameter byte_t OUTP_RST    = 8'hCF,
  parameter byte_t INPORT_VAL  = 8'h80,
  parameter byte_t SELFTEST_OK = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] status_o,
  input  logic       obf_in,
  input  logic       obf_aux_in,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  output logic       rsp_aux,
  input  logic       rsp_ready,
  output logic       kbd_tx_valid,
  output logic       aux_tx_valid,
  output logic [7:0] tx_data,
  output logic [7:0] mode_o,
  output logic       a20_out,
  output logic       sys_reset_req,
  output logic       cmd_err
);
  op_e      op;
  reg_upd_t upd;
  byte_t    mode_q, outp_q, wcmd_q;
  logic     selftest_q, cmdflag_q;
  logic     post, post_aux;
  byte_t    post_data;
  logic     kbd_d, aux_d, rst_d, err_d;

  kbc_cmd_decode u_dec (.cmd(bus_wdata), .op(op));

  kbc_ctrl_regs #(.MODE_RST(MODE_RST), .OUTP_RST(OUTP_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .upd(upd), .mode_q(mode_q), .outp_q(outp_q),
    .selftest_q(selftest_q), .cmdflag_q(cmdflag_q), .wcmd_q(wcmd_q)
  );

  kbc_rsp_mailbox #(.DATA_W(BYTE_W)) u_mbox (
    .clk(clk), .rst_n(rst_n), .post(post), .post_data(post_data),
    .post_aux(post_aux), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_aux(rsp_aux), .rsp_ready(rsp_ready)
  );

  always_comb begin
    upd       = '0;
    post      = 1'b0;
    post_data = '0;
    post_aux  = 1'b0;
    kbd_d     = 1'b0;
    aux_d     = 1'b0;
    rst_d     = 1'b0;
    err_d     = 1'b0;
    if (bus_wr && bus_addr) begin
      upd.cmdflag_we = 1'b1;
      upd.cmdflag_d  = 1'b1;
      case (op)
        OP_POST_MODE:   begin post = 1'b1; post_data = mode_q; end
        OP_POST_INPORT: begin post = 1'b1; post_data = INPORT_VAL; end
        OP_POST_OUTP: begin
          post      = 1'b1;
          post_data = {outp_q[7:6], obf_aux_in, obf_in, outp_q[3:0]};
        end
        OP_POST_ZERO:   post = 1'b1;
        OP_SELFTEST: begin
          upd.selftest_set = 1'b1;
          post             = 1'b1;
          post_data        = SELFTEST_OK;
        end
        OP_LATCH: begin upd.wcmd_we = 1'b1; upd.wcmd_d = bus_wdata; end
        OP_SET_AUXDIS: begin
          upd.mode_we = 1'b1; upd.mode_d = mode_q; upd.mode_d[MB_AUX_DIS] = 1'b1;
        end
        OP_CLR_AUXDIS: begin
          upd.mode_we = 1'b1; upd.mode_d = mode_q; upd.mode_d[MB_AUX_DIS] = 1'b0;
        end
        OP_SET_KBDDIS: begin
          upd.mode_we = 1'b1; upd.mode_d = mode_q; upd.mode_d[MB_KBD_DIS] = 1'b1;
        end
        OP_CLR_KBDDIS: begin
          upd.mode_we = 1'b1; upd.mode_d = mode_q; upd.mode_d[MB_KBD_DIS] = 1'b0;
        end
        OP_A20_UP: begin
          upd.outp_we = 1'b1; upd.outp_d = outp_q; upd.outp_d[OP_A20_BIT] = 1'b1;
        end
        OP_A20_DOWN: begin
          upd.outp_we = 1'b1; upd.outp_d = outp_q; upd.outp_d[OP_A20_BIT] = 1'b0;
        end
        OP_RESET: rst_d = 1'b1;
        OP_NOP:   ;
        default: begin
          err_d          = 1'b1;
          upd.cmdflag_we = 1'b0;
        end
      endcase
    end else if (bus_wr) begin
      upd.cmdflag_we = 1'b1;
      upd.cmdflag_d  = 1'b0;
      upd.wcmd_we    = 1'b1;
      upd.wcmd_d     = '0;
      case (wcmd_q)
        C_WR_MODE: begin upd.mode_we = 1'b1; upd.mode_d = bus_wdata; end
        C_WR_OUTP: begin
          upd.outp_we = 1'b1;
          upd.outp_d  = bus_wdata;
          rst_d       = ~bus_wdata[0];
        end
        C_WR_KBUF: begin post = 1'b1; post_data = bus_wdata; end
        C_WR_ABUF: begin post = 1'b1; post_data = bus_wdata; post_aux = 1'b1; end
        C_WR_AUXDEV: begin
          aux_d = 1'b1;
          upd.mode_we = 1'b1; upd.mode_d = mode_q; upd.mode_d[MB_AUX_DIS] = 1'b0;
        end
        default: begin
          kbd_d = 1'b1;
          upd.mode_we = 1'b1; upd.mode_d = mode_q; upd.mode_d[MB_KBD_DIS] = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kbd_tx_valid  <= 1'b0;
      aux_tx_valid  <= 1'b0;
      tx_data       <= '0;
      sys_reset_req <= 1'b0;
      cmd_err       <= 1'b0;
    end else begin
      kbd_tx_valid  <= kbd_d;
      aux_tx_valid  <= aux_d;
      if (kbd_d || aux_d) tx_data <= bus_wdata;
      sys_reset_req <= rst_d;
      cmd_err       <= err_d;
    end
  end

  assign status_o = {2'b00, obf_aux_in, 1'b1, cmdflag_q, selftest_q, 1'b0, obf_in};
  assign mode_o   = mode_q;
  assign a20_out  = outp_q[OP_A20_BIT];
endmodule

// File: rtl/kbc_cmd_decoder_chk.sv
module kbc_cmd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_addr,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic       kbd_tx_valid,
  input logic       aux_tx_valid,
  input logic       a20_out,
  input logic       sys_reset_req,
  input logic       cmd_err
);
  a_r5_reset_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> $past(bus_wr));
  a_r6_a20_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(a20_out) |-> $past(bus_wr));
  a_r8_tx_from_data_write: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_tx_valid || aux_tx_valid) |-> $past(bus_wr && !bus_addr));
  a_r8_tx_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(kbd_tx_valid && aux_tx_valid));
  a_r10_err_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(bus_wr && bus_addr));
  a_r10_err_no_post: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> !sys_reset_req && !(rsp_valid && !$past(rsp_valid)));
  a_r11_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready && !bus_wr) |=> rsp_valid && $stable(rsp_data));
endmodule

bind kbc_cmd_decoder kbc_cmd_decoder_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .kbd_tx_valid(kbd_tx_valid), .aux_tx_valid(aux_tx_valid),
  .a20_out(a20_out), .sys_reset_req(sys_reset_req), .cmd_err(cmd_err)
);

// File: tb/test_kbc_cmd_decoder.sv
module test_kbc_cmd_decoder;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] status_o, rsp_data, tx_data, mode_o;
  logic       obf_in = 1'b0, obf_aux_in = 1'b0, rsp_ready = 1'b0;
  logic       rsp_valid, rsp_aux, kbd_tx_valid, aux_tx_valid;
  logic       a20_out, sys_reset_req, cmd_err;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbc_cmd_decoder i_kbc_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .status_o(status_o), .obf_in(obf_in),
    .obf_aux_in(obf_aux_in), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_aux(rsp_aux), .rsp_ready(rsp_ready), .kbd_tx_valid(kbd_tx_valid),
    .aux_tx_valid(aux_tx_valid), .tx_data(tx_data), .mode_o(mode_o),
    .a20_out(a20_out), .sys_reset_req(sys_reset_req), .cmd_err(cmd_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pop(input string req, input logic [7:0] d, input logic aux);
    chk({req, " valid"}, rsp_valid, 1);
    chk({req, " data"}, rsp_data, d);
    chk({req, " aux"}, rsp_aux, aux);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk({req, " drained"}, rsp_valid, 0);
  endtask

  function automatic bit known(input int c);
    if (c >= 8'hF0) return 1'b1;
    case (c)
      8'h20, 8'h60, 8'hA7, 8'hA8, 8'hA9, 8'hAA, 8'hAB, 8'hAD, 8'hAE,
      8'hC0, 8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hD4, 8'hDD, 8'hDF: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 reset status", status_o, 8'h18);
    chk("R9 reset mode", mode_o, 8'h03);
    chk("R9 reset a20", a20_out, 1);
    chk("R9 reset mailbox", rsp_valid, 0);
    obf_in = 1'b1; obf_aux_in = 1'b1; #1;
    chk("R9 status obf flags", status_o, 8'h39);
    obf_in = 1'b0; obf_aux_in = 1'b0;

    // R1 reads
    wr(1, 8'h20); pop("R1 mode post", 8'h03, 0);
    chk("R9 cmd flag", status_o[3], 1);
    wr(1, 8'hC0); pop("R1 inport post", 8'h80, 0);
    obf_in = 1'b1;
    wr(1, 8'hD0); pop("R1 outport post obf", 8'hDF, 0);
    obf_in = 1'b0; obf_aux_in = 1'b1;
    wr(1, 8'hD0); pop("R1 outport post aux", 8'hEF, 0);
    obf_aux_in = 1'b0;

    // R3 tests
    wr(1, 8'hAA); chk("R3 selftest flag", status_o, 8'h1C); pop("R3 selftest", 8'h55, 0);
    wr(1, 8'hA9); pop("R3 aux test", 8'h00, 0);
    wr(1, 8'hAB); pop("R3 kbd test", 8'h00, 0);

    // R4 mode bits
    wr(1, 8'hA7); chk("R4 aux disable", mode_o, 8'h23);
    wr(1, 8'hA8); chk("R4 aux enable", mode_o, 8'h03);
    wr(1, 8'hAD); chk("R4 kbd disable", mode_o, 8'h13);

    // R8 keyboard path
    wr(0, 8'h5A);
    chk("R8 kbd strobe", kbd_tx_valid, 1);
    chk("R8 kbd data", tx_data, 8'h5A);
    chk("R8 aux quiet", aux_tx_valid, 0);
    chk("R8 kbd enable", mode_o, 8'h03);
    chk("R9 data flag", status_o, 8'h14);
    @(negedge clk); chk("R8 kbd one cycle", kbd_tx_valid, 0);
    wr(1, 8'hAD); wr(1, 8'hAE); chk("R4 kbd enable cmd", mode_o, 8'h03);
    wr(1, 8'hA7); wr(1, 8'hD4);
    chk("R2 latch no effect", mode_o, 8'h23);
    wr(0, 8'h77);
    chk("R8 aux strobe", aux_tx_valid, 1);
    chk("R8 aux data", tx_data, 8'h77);
    chk("R8 kbd quiet", kbd_tx_valid, 0);
    chk("R8 aux enable", mode_o, 8'h03);

    // R6 A20
    wr(1, 8'hDD); chk("R6 a20 low", a20_out, 0);
    wr(1, 8'hD0); pop("R6 outport bit1 clear", 8'hCD, 0);
    wr(1, 8'hDF); chk("R6 a20 high", a20_out, 1);

    // R2 write mode then latch cleared
    wr(1, 8'h60); chk("R2 no post", rsp_valid, 0);
    wr(0, 8'h45); chk("R2 mode load", mode_o, 8'h45); chk("R2 no kbd", kbd_tx_valid, 0);
    wr(0, 8'h11); chk("R2 latch cleared", kbd_tx_valid, 1);
    wr(1, 8'h60); wr(0, 8'h03); chk("R2 mode restore", mode_o, 8'h03);

    // R11 mailbox
    wr(1, 8'hD2); wr(0, 8'h9C); pop("R11 kbd buffer", 8'h9C, 0);
    wr(1, 8'hD3); wr(0, 8'h3A); pop("R11 aux buffer", 8'h3A, 1);
    wr(1, 8'hD2); wr(0, 8'h01);
    repeat (3) @(negedge clk);
    chk("R11 held valid", rsp_valid, 1);
    chk("R11 held data", rsp_data, 8'h01);
    wr(1, 8'hD2); wr(0, 8'h02); pop("R11 overwrite", 8'h02, 0);

    // R7 output port write
    wr(1, 8'hD1); wr(0, 8'h01);
    chk("R7 a20 from bit1", a20_out, 0); chk("R7 no reset", sys_reset_req, 0);
    wr(1, 8'hD1); wr(0, 8'h02);
    chk("R7 a20 set", a20_out, 1); chk("R7 reset pulse", sys_reset_req, 1);
    @(negedge clk); chk("R7 reset one cycle", sys_reset_req, 0);
    wr(1, 8'hD0); pop("R7 outport value", 8'h02, 0);
    wr(1, 8'hD1); wr(0, 8'hCF);

    // R5 pulse range sweep
    for (int c = 8'hF0; c <= 8'hFF; c++) begin
      wr(1, c[7:0]);
      chk($sformatf("R5 reset %0h", c), sys_reset_req, !c[0]);
      chk($sformatf("R5 no err %0h", c), cmd_err, 0);
      chk($sformatf("R5 no post %0h", c), rsp_valid, 0);
    end
    @(negedge clk); chk("R5 pulse ends", sys_reset_req, 0);

    // R10 unknown command sweep
    wr(0, 8'h00);
    for (int c = 0; c < 256; c++) begin
      if (!known(c)) begin
        wr(1, c[7:0]);
        chk($sformatf("R10 err %0h", c), cmd_err, 1);
        chk($sformatf("R10 no post %0h", c), rsp_valid, 0);
        chk($sformatf("R10 mode %0h", c), mode_o, 8'h03);
        chk($sformatf("R10 a20 %0h", c), a20_out, 1);
        chk($sformatf("R10 no reset %0h", c), sys_reset_req, 0);
        chk($sformatf("R10 status %0h", c), status_o, 8'h14);
      end
    end
    wr(1, 8'hD2); wr(1, 8'h01);
    chk("R10 latch kept", rsp_valid, 0);
    wr(0, 8'h66); pop("R10 latch survives unknown", 8'h66, 0);
    @(negedge clk); chk("R10 err one cycle", cmd_err, 0);
    summary();
  end
endmodule